// File: doc/BRIEF.md
# Physical memory type resolver

This block turns a physical address into the memory type that governs how the access may be cached. Software programs a small register file through a plain write/read port. The file holds three tiers of fixed-granularity slots that cover the lowest megabyte, a set of base/mask variable ranges that can sit anywhere in the physical space, a default type for unmatched addresses, a global enable, and an enable for the extended fixed-slot encoding. Each lookup carries the address and two page-level controls, cache-disable and write-through. The block merges every type that applies by strict restrictiveness and returns the result one cycle after the request is accepted.

Type codes: 0 = UC, 1 = WC, 4 = WT, 5 = WP, 6 = WB. The restrictiveness order, from most to least, is UC, WC, WP, WT, WB.

Register map (`cfg_addr`):
- 0x00 to 0x57 hold the fixed slots, with the type in `cfg_wdata[7:0]`. Slots 0 to 7 cover 0x00000 to 0x7FFFF in 64 KiB steps. Slots 8 to 23 cover 0x80000 to 0xBFFFF in 16 KiB steps. Slots 24 to 87 cover 0xC0000 to 0xFFFFF in 4 KiB steps.
- For variable range i, address 0x60+2i is the base word: base in `[PA_W-1:12]` and type in `[7:0]`. Address 0x61+2i is the mask word: mask in `[PA_W-1:12]` and valid flag in bit 11.
- 0x70 is the control word: default type in `[7:0]`, global enable in bit 8, extended-encoding enable in bit 9.

Unknown addresses read back zero and ignore writes.

The lookup side is valid/ready on both ends. A request is taken when `req_valid && req_ready`. `req_ready` is high whenever the result register is empty or its content is consumed in the same cycle, so a result stalled by a low `res_ready` back-pressures new requests. A held result keeps its value until it is taken.

Top module: `memtype_resolver`

## Requirements
- R1: A result only ever carries one of the codes 0, 1, 4, 5 or 6.
- R2: With the global enable (control bit 8) clear, every lookup returns UC, whatever the page controls or ranges say.
- R3: An address below 0x100000 takes the type of its fixed slot. Slots 0 to 7 cover 64 KiB each from 0x00000, slots 8 to 23 cover 16 KiB each from 0x80000, and slots 24 to 87 cover 4 KiB each from 0xC0000.
- R4: Variable range i matches when its valid flag is set and `(addr & mask) == (base & mask)` over bits `[PA_W-1:12]`. A range with the flag clear never matches.
- R5: When several sources apply (a fixed slot and one or more variable ranges), the result is the most restrictive of them in the order UC, WC, WP, WT, WB.
- R6: An address matched by no fixed slot and no valid variable range takes the default type.
- R7: A set page cache-disable input forces UC.
- R8: A set page write-through input turns a WB result into WT and leaves every other type unchanged.
- R9: A write whose type field is not a legal code (bits 2:0 in {2, 3, 7}, or reserved bits set) is rejected. The target register keeps its value, and `cfg_err` is high in the cycle after that write and low after accepted writes.
- R10: Extended type fields, where bits 4:3 are read/write-to-memory flags and bits 7:5 are zero, are accepted only in fixed slots and only while control bit 9 is set. Variable-range and default type fields accept only standard codes. Lookup uses bits 2:0 of the field.
- R11: A result appears on `res_type` with `res_valid` high in the cycle after the request is accepted. While `res_valid && !res_ready`, the result holds and `req_ready` is low.
- R12: After reset `res_valid` and `cfg_err` are low, `req_ready` is high, and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration register address |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read data for `cfg_addr` (combinational) |
| cfg_err | output | 1 | Previous-cycle write was rejected |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_addr | input | PA_W | Physical address to resolve |
| req_pcd | input | 1 | Page-level cache-disable |
| req_pwt | input | 1 | Page-level write-through |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result consumer ready |
| res_type | output | 3 | Effective memory type code |

## Verification
A vector table hits the first and last byte of each fixed tier and unprogrammed slots next to programmed ones, which shows whether the tier boundaries and slot indexing are right. Variable-range vectors separate a valid single match, an overlap of two ranges, an overlap of a range with a fixed slot, and a disabled range that must fall through to the default. Page-control vectors apply write-through to WB and to non-WB regions and cache-disable to a WB region, which tells a correct one-way override from one that relaxes a type. Directed tests cover rejected writes, extended encodings, stall and release of the result register, and the global disable.

// File: rtl/memtype_pkg.sv
package memtype_pkg;
  localparam logic [2:0] MT_UC = 3'd0;
  localparam logic [2:0] MT_WC = 3'd1;
  localparam logic [2:0] MT_WT = 3'd4;
  localparam logic [2:0] MT_WP = 3'd5;
  localparam logic [2:0] MT_WB = 3'd6;

  // Fixed-range tiers inside the lowest megabyte
  localparam int N_SLOT64 = 8;
  localparam int N_SLOT16 = 16;
  localparam int N_SLOT4  = 64;
  localparam int N_FIX    = N_SLOT64 + N_SLOT16 + N_SLOT4;

  function automatic logic [2:0] mt_rank(input logic [2:0] t);
    case (t)
      MT_UC:   return 3'd0;
      MT_WC:   return 3'd1;
      MT_WP:   return 3'd2;
      MT_WT:   return 3'd3;
      MT_WB:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] mt_stricter(input logic [2:0] a, input logic [2:0] b);
    return (mt_rank(a) <= mt_rank(b)) ? a : b;
  endfunction

  function automatic logic mt_code_ok(input logic [2:0] t);
    return (t == MT_UC) || (t == MT_WC) || (t == MT_WT) || (t == MT_WP) || (t == MT_WB);
  endfunction

  function automatic logic mt_field_ok(input logic [7:0] f, input logic ext_ok);
    return mt_code_ok(f[2:0]) && (f[7:5] == 3'b000) && (ext_ok || (f[4:3] == 2'b00));
  endfunction
endpackage

// File: rtl/memtype_cfg_regs.sv
module memtype_cfg_regs
  import memtype_pkg::*;
#(
  parameter int PA_W     = 40,
  parameter int N_VAR    = 8,
  parameter int VAR_ADDR = 'h60
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [7:0]                      cfg_addr,
  input  logic [63:0]                     cfg_wdata,
  output logic [63:0]                     cfg_rdata,
  output logic                            cfg_err,
  output logic [N_FIX-1:0][7:0]           fix_q,
  output logic [N_VAR-1:0][PA_W-13:0]     var_base,
  output logic [N_VAR-1:0][PA_W-13:0]     var_mask,
  output logic [N_VAR-1:0][2:0]           var_type,
  output logic [N_VAR-1:0]                var_vld,
  output logic [2:0]                      dflt_type,
  output logic                            glb_en,
  output logic                            ext_en
);
  localparam int PG_W = PA_W - 12;
  localparam int VS_W = (N_VAR > 1) ? $clog2(N_VAR) : 1;
  localparam logic [7:0] FIX_END  = 8'(N_FIX);
  localparam logic [7:0] VAR_LO   = 8'(VAR_ADDR);
  localparam logic [7:0] VAR_END  = 8'(VAR_ADDR + 2 * N_VAR);
  localparam logic [7:0] CTRL_ADR = VAR_END;

  logic            hit_fix, hit_var, hit_ctrl, var_hi;
  logic [7:0]      var_off;
  logic [VS_W-1:0] var_sel;
  logic [6:0]      fix_idx;
  logic [7:0]      wd8;
  logic            fix_ok, std_ok;
  logic            unused_bits;

  assign hit_fix  = cfg_addr < FIX_END;
  assign hit_var  = (cfg_addr >= VAR_LO) && (cfg_addr < VAR_END);
  assign hit_ctrl = cfg_addr == CTRL_ADR;
  assign var_off  = cfg_addr - VAR_LO;
  assign var_sel  = var_off[VS_W:1];
  assign var_hi   = var_off[0];
  assign fix_idx  = cfg_addr[6:0];
  assign wd8      = cfg_wdata[7:0];
  assign fix_ok   = mt_field_ok(wd8, ext_en);
  assign std_ok   = mt_field_ok(wd8, 1'b0);
  assign unused_bits = ^{cfg_wdata[63:PA_W], cfg_wdata[10]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fix_q     <= '0;
      var_base  <= '0;
      var_mask  <= '0;
      var_type  <= '0;
      var_vld   <= '0;
      dflt_type <= MT_UC;
      glb_en    <= 1'b0;
      ext_en    <= 1'b0;
      cfg_err   <= 1'b0;
    end else begin
      cfg_err <= 1'b0;
      if (cfg_we) begin
        if (hit_fix) begin
          if (fix_ok) fix_q[fix_idx] <= wd8;
          else        cfg_err        <= 1'b1;
        end else if (hit_var) begin
          if (var_hi) begin
            var_mask[var_sel] <= cfg_wdata[PA_W-1:12];
            var_vld[var_sel]  <= cfg_wdata[11];
          end else if (std_ok) begin
            var_base[var_sel] <= cfg_wdata[PA_W-1:12];
            var_type[var_sel] <= wd8[2:0];
          end else begin
            cfg_err <= 1'b1;
          end
        end else if (hit_ctrl) begin
          if (std_ok) begin
            dflt_type <= wd8[2:0];
            glb_en    <= cfg_wdata[8];
            ext_en    <= cfg_wdata[9];
          end else begin
            cfg_err <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (hit_fix) begin
      cfg_rdata[7:0] = fix_q[fix_idx];
    end else if (hit_var) begin
      if (var_hi) begin
        cfg_rdata[PA_W-1:12] = var_mask[var_sel];
        cfg_rdata[11]        = var_vld[var_sel];
      end else begin
        cfg_rdata[PA_W-1:12] = var_base[var_sel];
        cfg_rdata[2:0]       = var_type[var_sel];
      end
    end else if (hit_ctrl) begin
      cfg_rdata[2:0] = dflt_type;
      cfg_rdata[8]   = glb_en;
      cfg_rdata[9]   = ext_en;
    end
  end

  // R9: an error pulse only follows a write
  a_r9_err_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_we));
  // R9: a rejected fixed-slot write leaves the slots untouched
  a_r9_fix_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hit_fix && !fix_ok) |=> $stable(fix_q));
  // R10: extended flags in a variable-range type field are refused
  a_r10_var_std: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && hit_var && !var_hi && (cfg_wdata[4:3] != 2'b00)) |=> cfg_err);
  // R1: stored default type is always a legal code
  a_r1_dflt_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mt_code_ok(dflt_type));
endmodule

// File: rtl/memtype_fixed_lookup.sv
module memtype_fixed_lookup
  import memtype_pkg::*;
#(
  parameter int PA_W = 40
) (
  input  logic [PA_W-13:0]      pg_addr,
  input  logic [N_FIX-1:0][7:0] fix_q,
  output logic                  fix_hit,
  output logic [2:0]            fix_type
);
  localparam int PG_W = PA_W - 12;
  localparam logic [6:0] BASE16 = 7'(N_SLOT64);
  localparam logic [6:0] BASE4  = 7'(N_SLOT64 + N_SLOT16);

  logic [6:0] slot;

  always_comb begin
    fix_hit = (pg_addr[PG_W-1:8] == '0);
    if (!pg_addr[7])      slot = {4'b0, pg_addr[6:4]};
    else if (!pg_addr[6]) slot = BASE16 + {3'b0, pg_addr[5:2]};
    else                  slot = BASE4 + {1'b0, pg_addr[5:0]};
    fix_type = fix_q[slot][2:0];
  end
endmodule

// File: rtl/memtype_var_match.sv
module memtype_var_match
  import memtype_pkg::*;
#(
  parameter int PA_W  = 40,
  parameter int N_VAR = 8
) (
  input  logic [PA_W-13:0]              pg_addr,
  input  logic [N_VAR-1:0][PA_W-13:0]   var_base,
  input  logic [N_VAR-1:0][PA_W-13:0]   var_mask,
  input  logic [N_VAR-1:0][2:0]         var_type,
  input  logic [N_VAR-1:0]              var_vld,
  output logic                          var_hit,
  output logic [2:0]                    var_res
);
  logic [N_VAR-1:0] hit;

  for (genvar i = 0; i < N_VAR; i++) begin : g_ent
    assign hit[i] = var_vld[i] &&
                    ((pg_addr & var_mask[i]) == (var_base[i] & var_mask[i]));
  end

  always_comb begin
    var_res = MT_WB;
    for (int i = 0; i < N_VAR; i++) begin
      if (hit[i]) var_res = mt_stricter(var_res, var_type[i]);
    end
    var_hit = |hit;
  end
endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
  import memtype_pkg::*;
#(
  parameter int PA_W     = 40,
  parameter int N_VAR    = 8,
  parameter int VAR_ADDR = 'h60
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [7:0]      cfg_addr,
  input  logic [63:0]     cfg_wdata,
  output logic [63:0]     cfg_rdata,
  output logic            cfg_err,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [PA_W-1:0] req_addr,
  input  logic            req_pcd,
  input  logic            req_pwt,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [2:0]      res_type
);
  localparam int PG_W = PA_W - 12;

  logic [N_FIX-1:0][7:0]       fix_q;
  logic [N_VAR-1:0][PG_W-1:0]  var_base, var_mask;
  logic [N_VAR-1:0][2:0]       var_type;
  logic [N_VAR-1:0]            var_vld;
  logic [2:0]                  dflt_type;
  logic                        glb_en, ext_en;
  logic [PG_W-1:0]             pg_addr;
  logic                        fix_hit, var_hit;
  logic [2:0]                  fix_type, var_res, range_t, eff_t;
  logic                        fire;
  logic                        unused_lo;

  assign pg_addr   = req_addr[PA_W-1:12];
  assign unused_lo = ^req_addr[11:0];

  memtype_cfg_regs #(.PA_W(PA_W), .N_VAR(N_VAR), .VAR_ADDR(VAR_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .fix_q(fix_q), .var_base(var_base), .var_mask(var_mask),
    .var_type(var_type), .var_vld(var_vld), .dflt_type(dflt_type),
    .glb_en(glb_en), .ext_en(ext_en)
  );

  memtype_fixed_lookup #(.PA_W(PA_W)) u_fix (
    .pg_addr(pg_addr), .fix_q(fix_q), .fix_hit(fix_hit), .fix_type(fix_type)
  );

  memtype_var_match #(.PA_W(PA_W), .N_VAR(N_VAR)) u_var (
    .pg_addr(pg_addr), .var_base(var_base), .var_mask(var_mask),
    .var_type(var_type), .var_vld(var_vld), .var_hit(var_hit), .var_res(var_res)
  );

  // Range merge, then page-level overrides
  always_comb begin
    if (!glb_en)                range_t = MT_UC;
    else if (fix_hit && var_hit) range_t = mt_stricter(fix_type, var_res);
    else if (fix_hit)           range_t = fix_type;
    else if (var_hit)           range_t = var_res;
    else                        range_t = dflt_type;

    if (req_pcd)                         eff_t = MT_UC;
    else if (req_pwt && range_t == MT_WB) eff_t = MT_WT;
    else                                 eff_t = range_t;
  end

  assign req_ready = !res_valid || res_ready;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_type  <= MT_UC;
    end else if (fire) begin
      res_valid <= 1'b1;
      res_type  <= eff_t;
    end else if (res_ready) begin
      res_valid <= 1'b0;
    end
  end

  a_r1_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> mt_code_ok(res_type));
  a_r2_disabled_uc: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !glb_en) |=> (res_type == MT_UC));
  a_r7_pcd_uc: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_pcd) |=> (res_type == MT_UC));
  a_r8_pwt_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && req_pwt) |=> (res_type != MT_WB));
  a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> res_valid);
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_type)));
endmodule

// File: tb/memtype_resolver_test.sv
module memtype_resolver_test;
  localparam int PA_W = 40;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_we = 1'b0;
  logic [7:0]      cfg_addr = '0;
  logic [63:0]     cfg_wdata = '0;
  logic [63:0]     cfg_rdata;
  logic            cfg_err;
  logic            req_valid = 1'b0;
  logic            req_ready;
  logic [PA_W-1:0] req_addr = '0;
  logic            req_pcd = 1'b0;
  logic            req_pwt = 1'b0;
  logic            res_valid;
  logic            res_ready = 1'b1;
  logic [2:0]      res_type;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memtype_resolver #(.PA_W(PA_W)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_pcd(req_pcd), .req_pwt(req_pwt), .res_valid(res_valid),
    .res_ready(res_ready), .res_type(res_type)
  );

  // {pcd, pwt, expected type, address}
  localparam logic [44:0] VEC [18] = '{
    {1'b0, 1'b0, 3'd6, 40'h00000},   // R3 first 64K slot
    {1'b0, 1'b0, 3'd6, 40'h0FFFF},   // R3 end of slot 0
    {1'b0, 1'b0, 3'd0, 40'h10000},   // R3 slot 1 unprogrammed
    {1'b0, 1'b0, 3'd1, 40'h7FFFF},   // R3 last 64K slot
    {1'b0, 1'b0, 3'd5, 40'h80000},   // R3 first 16K slot
    {1'b0, 1'b0, 3'd0, 40'h84000},   // R3 next 16K slot
    {1'b0, 1'b0, 3'd4, 40'hBFFFF},   // R3 last 16K slot
    {1'b0, 1'b0, 3'd6, 40'hC0000},   // R3 first 4K slot
    {1'b0, 1'b0, 3'd0, 40'hC1000},   // R3 next 4K slot
    {1'b0, 1'b0, 3'd4, 40'hFF000},   // R5 fixed WB vs range WT
    {1'b0, 1'b0, 3'd6, 40'h100000},  // R4 single range
    {1'b0, 1'b0, 3'd4, 40'h180000},  // R5 WB and WT overlap
    {1'b0, 1'b0, 3'd6, 40'h200000},  // R4 invalid range -> R6 default
    {1'b0, 1'b0, 3'd6, 40'h300000},  // R6 default
    {1'b0, 1'b1, 3'd4, 40'h100000},  // R8 WB -> WT
    {1'b0, 1'b1, 3'd1, 40'h7FFFF},   // R8 WC unchanged
    {1'b1, 1'b0, 3'd0, 40'h100000},  // R7 forced UC
    {1'b0, 1'b1, 3'd4, 40'h180000}   // R8 WT unchanged
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d, output logic err);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    err = cfg_err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic look(input logic [PA_W-1:0] a, input logic pcd, input logic pwt,
                      output logic v, output logic [2:0] t);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_pcd = pcd; req_pwt = pwt;
    @(negedge clk);
    req_valid = 1'b0;
    v = res_valid; t = res_type;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11: watchdog timeout, actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic        e, v;
    logic [2:0]  t;
    logic [63:0] d;

    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 res_valid", 64'(res_valid), 64'd0);
    chk("R12 req_ready", 64'(req_ready), 64'd1);
    chk("R12 cfg_err", 64'(cfg_err), 64'd0);
    rst_n = 1'b1;
    rd(8'h00, d); chk("R12 slot0", d, 64'h0);
    rd(8'h70, d); chk("R12 ctrl", d, 64'h0);
    rd(8'h61, d); chk("R12 var0 mask", d, 64'h0);
    look(40'h100000, 1'b0, 1'b0, v, t);
    chk("R2 disabled after reset", 64'(t), 64'd0);
    chk("R11 valid after one cycle", 64'(v), 64'd1);

    // Program fixed slots
    wr(8'd0,  64'h06, e);
    chk("R9 good write no err", 64'(e), 64'd0);
    wr(8'd7,  64'h01, e);
    wr(8'd8,  64'h05, e);
    wr(8'd23, 64'h04, e);
    wr(8'd24, 64'h06, e);
    wr(8'd87, 64'h06, e);
    // Variable ranges
    wr(8'h60, 64'h0000_0000_0010_0006, e);
    wr(8'h61, 64'h0000_00FF_FFF0_0800, e);
    wr(8'h62, 64'h0000_0000_0018_0004, e);
    wr(8'h63, 64'h0000_00FF_FFF8_0800, e);
    wr(8'h64, 64'h0000_0000_0020_0001, e);
    wr(8'h65, 64'h0000_00FF_FFF0_0000, e);
    wr(8'h66, 64'h0000_0000_000F_0004, e);
    wr(8'h67, 64'h0000_00FF_FFFF_0800, e);
    rd(8'h62, d); chk("R4 var1 base readback", d, 64'h0000_0000_0018_0004);
    wr(8'h70, 64'h106, e);

    res_ready = 1'b1;
    for (int i = 0; i < 18; i++) begin
      look(VEC[i][39:0], VEC[i][44], VEC[i][43], v, t);
      chk($sformatf("R3-table vector %0d (R4 R5 R6 R7 R8)", i), 64'(t), 64'(VEC[i][42:40]));
      chk("R1 R11 valid", 64'(v), 64'd1);
    end

    // R9 reserved code rejected, value kept
    wr(8'd0, 64'h02, e);
    chk("R9 err on code 2", 64'(e), 64'd1);
    rd(8'd0, d); chk("R9 slot0 kept", d, 64'h06);
    wr(8'h70, 64'h107, e);
    chk("R9 err on code 7", 64'(e), 64'd1);
    rd(8'h70, d); chk("R9 ctrl kept", d, 64'h106);
    look(40'h0, 1'b0, 1'b0, v, t);
    chk("R9 lookup unchanged", 64'(t), 64'd6);

    // R10 extended encoding
    wr(8'd1, 64'h1E, e);
    chk("R10 ext refused when off", 64'(e), 64'd1);
    rd(8'd1, d); chk("R10 slot1 kept", d, 64'h0);
    wr(8'h70, 64'h306, e);
    wr(8'd1, 64'h1E, e);
    chk("R10 ext accepted", 64'(e), 64'd0);
    rd(8'd1, d); chk("R10 slot1 readback", d, 64'h1E);
    look(40'h10000, 1'b0, 1'b0, v, t);
    chk("R10 lookup low bits", 64'(t), 64'd6);
    wr(8'h68, 64'h0000_0000_0040_001E, e);
    chk("R10 var refuses ext", 64'(e), 64'd1);
    rd(8'h68, d); chk("R10 var4 base kept", d, 64'h0);

    // R11 back-pressure
    @(negedge clk);
    res_ready = 1'b0; req_valid = 1'b1; req_addr = 40'h0; req_pcd = 1'b0; req_pwt = 1'b0;
    @(negedge clk);
    req_addr = 40'h84000;
    chk("R11 result under stall", 64'(res_type), 64'd6);
    chk("R11 req_ready low", 64'(req_ready), 64'd0);
    @(negedge clk);
    chk("R11 result held", 64'(res_type), 64'd6);
    chk("R11 valid held", 64'(res_valid), 64'd1);
    res_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R11 next result after release", 64'(res_type), 64'd0);
    @(negedge clk);
    chk("R11 drained", 64'(res_valid), 64'd0);

    // R2 global disable
    wr(8'h70, 64'h006, e);
    look(40'h100000, 1'b0, 1'b0, v, t);
    chk("R2 disabled gives UC", 64'(t), 64'd0);
    look(40'h0, 1'b0, 1'b1, v, t);
    chk("R2 disabled fixed gives UC", 64'(t), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule